// File: doc/BRIEF.md
# Load-Use Stall Controller

This block lives in the decode stage of a five-stage in-order pipeline. It looks at the instruction now in execute and the instruction now in decode. If the execute instruction is a load, and its destination register equals one of the decode instruction's source registers, the loaded value cannot reach the decode instruction in time, even with forwarding. The controller then freezes fetch and decode for one cycle and slips a no-op into execute.

The no-op is made by clearing the decoded control word as it enters the decode/execute register. The instruction word is left alone, because decoding has already turned it into control signals. A thin model of the front pipeline registers surrounds the controller so that the hold and the bubble can be seen at the ports. That model holds the program counter, the fetch/decode register and the decode/execute register.

The stall ends by itself. After one cycle the load has moved past execute, and the bubble that took its place has no memory-read bit. From then on, forwarding can supply the value.

Top module: `load_use_stall`

## Requirements
- R1: A stall is raised in the same cycle that the execute-stage control word has its memory-read bit set (bit 1) and the execute destination equals the decode instruction's first source register. During a stall `pcWrEn` and `ifIdWrEn` are 0 and `bubbleSel` is 1.
- R2: A stall is also raised when the execute load's destination equals the decode instruction's second source register.
- R3: No stall is raised when the execute instruction does not read memory, even if its destination matches a decode source register.
- R4: `pcOut` keeps its value across a clock edge at which `pcWrEn` is 0. Otherwise it advances by 4.
- R5: The fetch/decode register keeps its contents across a stall edge, so the held instruction enters execute one cycle later with its own control word.
- R6: The control word loaded into the decode/execute register at a stall edge is all zeros. The following cycle `exCtl` reads 0.
- R7: Each load-use pair costs exactly one stall cycle. The cycle after a stall has no stall unless a new load sits in execute.
- R8: While reset is low, `pcOut` is 0, `exCtl` is 0, both write enables are 1 and `bubbleSel` is 0.
- R9: A load whose address depends on the load just before it stalls once. When the next instruction then uses the second load's result, a second, separate one-cycle stall follows.
- R10: A dependent instruction two slots after a load causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchCtl | input | CTRL_W | Decoded control word of the fetched instruction (bit 1 = memory read) |
| fetchSrcA | input | REG_W | First source register of the fetched instruction |
| fetchSrcB | input | REG_W | Second source register of the fetched instruction |
| fetchDst | input | REG_W | Destination register of the fetched instruction |
| pcOut | output | PC_W | Program counter used as the fetch address |
| pcWrEn | output | 1 | Program counter write enable |
| ifIdWrEn | output | 1 | Fetch/decode register write enable |
| bubbleSel | output | 1 | Forces the control word entering execute to zero |
| exCtl | output | CTRL_W | Control word held in the decode/execute register |

## Verification
A wrong match or a lost memory-read bit shows at once: the enables drop or fail to drop in that very cycle, and `pcOut` is off by 4 one edge later. A bubble that is not cleared, or a fetch/decode register that is not held, shows on `exCtl` one edge after the stall. A controller that fails to release shows as a second cycle with `pcOut` frozen. Each program is checked against a per-cycle trace worked out from the requirements.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int unsigned DEF_REG_W  = 5;
  localparam int unsigned DEF_CTRL_W = 8;
  localparam int unsigned DEF_PC_W   = 16;

  // Strobes from the stall control to the pipeline registers
  typedef struct packed {
    logic pcWr;
    logic ifIdWr;
    logic bubble;
  } stall_strobe_t;
endpackage

// File: rtl/hzd_stall_ctrl.sv
module hzd_stall_ctrl
  import hzd_pkg::*;
#(
  parameter int unsigned REG_W   = DEF_REG_W,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            exMemRead,
  input  logic [REG_W-1:0]                exDst,
  input  logic [NUM_SRC-1:0][REG_W-1:0]   decSrc,
  output stall_strobe_t                   strobe
);
  logic [NUM_SRC-1:0] srcHit;
  logic               stall;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_cmp
    assign srcHit[s] = (decSrc[s] == exDst);
  end

  assign stall = exMemRead && (|srcHit);

  always_comb begin
    strobe.pcWr   = !stall;
    strobe.ifIdWr = !stall;
    strobe.bubble = stall;
  end

  // R7: the bubble removes the load from execute, so a stall never lasts two cycles
  a_r7_single_stall: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !stall);

endmodule

// File: rtl/hzd_pipe_regs.sv
module hzd_pipe_regs
  import hzd_pkg::*;
#(
  parameter int unsigned REG_W     = DEF_REG_W,
  parameter int unsigned CTRL_W    = DEF_CTRL_W,
  parameter int unsigned PC_W      = DEF_PC_W,
  parameter int unsigned NUM_SRC   = 2,
  parameter int unsigned MEMRD_BIT = 1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  stall_strobe_t                   strobe,
  input  logic [CTRL_W-1:0]               fetchCtl,
  input  logic [NUM_SRC-1:0][REG_W-1:0]   fetchSrc,
  input  logic [REG_W-1:0]                fetchDst,
  output logic [PC_W-1:0]                 pcOut,
  output logic [NUM_SRC-1:0][REG_W-1:0]   decSrc,
  output logic                            exMemRead,
  output logic [REG_W-1:0]                exDst,
  output logic [CTRL_W-1:0]               exCtl
);
  localparam logic [PC_W-1:0] PC_STEP = PC_W'(4);

  logic [PC_W-1:0]                pcQ;
  logic [CTRL_W-1:0]              idCtlQ;
  logic [NUM_SRC-1:0][REG_W-1:0]  idSrcQ;
  logic [REG_W-1:0]               idDstQ;
  logic [CTRL_W-1:0]              exCtlQ;
  logic [REG_W-1:0]               exDstQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pcQ <= '0;
    else if (strobe.pcWr) pcQ <= pcQ + PC_STEP;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idCtlQ <= '0;
      idSrcQ <= '0;
      idDstQ <= '0;
    end else if (strobe.ifIdWr) begin
      idCtlQ <= fetchCtl;
      idSrcQ <= fetchSrc;
      idDstQ <= fetchDst;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      exCtlQ <= '0;
      exDstQ <= '0;
    end else begin
      exCtlQ <= strobe.bubble ? '0 : idCtlQ;
      exDstQ <= idDstQ;
    end
  end

  assign pcOut     = pcQ;
  assign decSrc    = idSrcQ;
  assign exMemRead = exCtlQ[MEMRD_BIT];
  assign exDst     = exDstQ;
  assign exCtl     = exCtlQ;

  // R4: PC frozen on a disabled edge, otherwise steps by 4
  a_r4_pc_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.pcWr |=> $stable(pcQ));
  a_r4_pc_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pcWr |=> (pcQ == $past(pcQ) + PC_STEP));
  // R5: decode contents held through a stall
  a_r5_ifid_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ifIdWr |=> ($stable(idCtlQ) && $stable(idSrcQ)));
  // R6: a bubble leaves an all-zero control word in execute
  a_r6_bubble_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.bubble |=> (exCtlQ == '0));

endmodule

// File: rtl/load_use_stall.sv
module load_use_stall
  import hzd_pkg::*;
#(
  parameter int unsigned REG_W     = DEF_REG_W,
  parameter int unsigned CTRL_W    = DEF_CTRL_W,
  parameter int unsigned PC_W      = DEF_PC_W,
  parameter int unsigned MEMRD_BIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTRL_W-1:0] fetchCtl,
  input  logic [REG_W-1:0]  fetchSrcA,
  input  logic [REG_W-1:0]  fetchSrcB,
  input  logic [REG_W-1:0]  fetchDst,
  output logic [PC_W-1:0]   pcOut,
  output logic              pcWrEn,
  output logic              ifIdWrEn,
  output logic              bubbleSel,
  output logic [CTRL_W-1:0] exCtl
);
  localparam int unsigned NUM_SRC = 2;

  stall_strobe_t                  strobe;
  logic [NUM_SRC-1:0][REG_W-1:0]  fetchSrc;
  logic [NUM_SRC-1:0][REG_W-1:0]  decSrc;
  logic                           exMemRead;
  logic [REG_W-1:0]               exDst;

  assign fetchSrc = {fetchSrcB, fetchSrcA};

  hzd_stall_ctrl #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) i_ctrl (
    .clk(clk), .rstN(rstN), .exMemRead(exMemRead), .exDst(exDst),
    .decSrc(decSrc), .strobe(strobe)
  );

  hzd_pipe_regs #(.REG_W(REG_W), .CTRL_W(CTRL_W), .PC_W(PC_W),
                  .NUM_SRC(NUM_SRC), .MEMRD_BIT(MEMRD_BIT)) i_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fetchCtl(fetchCtl),
    .fetchSrc(fetchSrc), .fetchDst(fetchDst), .pcOut(pcOut),
    .decSrc(decSrc), .exMemRead(exMemRead), .exDst(exDst), .exCtl(exCtl)
  );

  assign pcWrEn    = strobe.pcWr;
  assign ifIdWrEn  = strobe.ifIdWr;
  assign bubbleSel = strobe.bubble;

endmodule

// File: tb/test_load_use_stall.sv
module test_load_use_stall;
  // control word: bit0 reg write, bit1 memory read
  localparam logic [7:0] C_LD  = 8'h0B;
  localparam logic [7:0] C_ADD = 8'h01;
  localparam logic [7:0] C_AND = 8'h11;
  localparam logic [7:0] C_OR  = 8'h21;
  localparam logic [7:0] C_AD2 = 8'h41;
  localparam logic [7:0] C_SUB = 8'h81;

  typedef struct packed {
    logic [7:0] ctl;
    logic [4:0] a;
    logic [4:0] b;
    logic [4:0] d;
  } ins_t;

  typedef struct {
    logic [15:0] pc;
    logic        pcWr;
    logic        ifIdWr;
    logic        bub;
    logic [7:0]  ctl;
    string       tag;
  } exp_t;

  logic        clk = 0;
  logic        rstN = 0;
  logic [7:0]  fetchCtl;
  logic [4:0]  fetchSrcA, fetchSrcB, fetchDst;
  logic [15:0] pcOut;
  logic        pcWrEn, ifIdWrEn, bubbleSel;
  logic [7:0]  exCtl;

  ins_t prog [16];
  exp_t expQ [$];
  int   nChecks = 0;
  int   nFails  = 0;
  int   cycles  = 0;

  always #10 clk = ~clk;  // 50 MHz

  assign fetchCtl  = prog[pcOut[5:2]].ctl;
  assign fetchSrcA = prog[pcOut[5:2]].a;
  assign fetchSrcB = prog[pcOut[5:2]].b;
  assign fetchDst  = prog[pcOut[5:2]].d;

  load_use_stall i_load_use_stall (
    .clk(clk), .rstN(rstN), .fetchCtl(fetchCtl), .fetchSrcA(fetchSrcA),
    .fetchSrcB(fetchSrcB), .fetchDst(fetchDst), .pcOut(pcOut),
    .pcWrEn(pcWrEn), .ifIdWrEn(ifIdWrEn), .bubbleSel(bubbleSel), .exCtl(exCtl)
  );

  // monitor: pops one expected item per cycle and compares
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      nChecks++;
      if (pcOut !== e.pc || pcWrEn !== e.pcWr || ifIdWrEn !== e.ifIdWr ||
          bubbleSel !== e.bub || exCtl !== e.ctl) begin
        nFails++;
        $display("FAIL %s: pc=%0d wr=%b/%b bub=%b ctl=%h expected pc=%0d wr=%b/%b bub=%b ctl=%h",
                 e.tag, pcOut, pcWrEn, ifIdWrEn, bubbleSel, exCtl,
                 e.pc, e.pcWr, e.ifIdWr, e.bub, e.ctl);
      end
    end
  end

  task automatic push(input int pc, input logic en, input logic [7:0] ctl, input string tag);
    exp_t e;
    e.pc = 16'(pc); e.pcWr = en; e.ifIdWr = en; e.bub = !en; e.ctl = ctl; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic clearProg();
    for (int i = 0; i < 16; i++) prog[i] = '0;
  endtask

  task automatic startRun();
    @(posedge clk); #1;
    rstN = 0;
    push(0, 1'b1, 8'h00, "R8 reset");
    @(posedge clk); #1;
    rstN = 1;
    push(0, 1'b1, 8'h00, "R8 after release");
    push(4, 1'b1, 8'h00, "R8 first step");
  endtask

  task automatic drain();
    while (expQ.size() > 0) @(posedge clk);
  endtask

  initial begin
    clearProg();
    // A: load then two dependents, first uses srcA
    prog[0] = '{C_LD,  5'd1, 5'd0, 5'd2};
    prog[1] = '{C_AND, 5'd2, 5'd5, 5'd4};
    prog[2] = '{C_OR,  5'd4, 5'd2, 5'd4};
    prog[3] = '{C_AD2, 5'd4, 5'd2, 5'd9};
    startRun();
    push(8,  1'b0, C_LD,  "R1 stall on srcA");
    push(8,  1'b1, 8'h00, "R6 bubble R4 pc held R7 released");
    push(12, 1'b1, C_AND, "R5 held instr enters execute");
    push(16, 1'b1, C_OR,  "R10 later dependent no stall");
    push(20, 1'b1, C_AD2, "R4 pc steps");
    drain();

    // B: non-load producer and dependent two slots after a load
    clearProg();
    prog[0] = '{C_ADD, 5'd1, 5'd3, 5'd2};
    prog[1] = '{C_AND, 5'd2, 5'd5, 5'd4};
    prog[2] = '{C_LD,  5'd1, 5'd0, 5'd6};
    prog[3] = '{C_AD2, 5'd8, 5'd9, 5'd7};
    prog[4] = '{C_OR,  5'd6, 5'd5, 5'd4};
    startRun();
    push(8,  1'b1, C_ADD, "R3 no load no stall");
    push(12, 1'b1, C_AND, "R3 pipeline flows");
    push(16, 1'b1, C_LD,  "R10 load in execute unrelated decode");
    push(20, 1'b1, C_AD2, "R10 two slots after load no stall");
    push(24, 1'b1, C_OR,  "R10 dependent enters execute");
    drain();

    // C: srcB match and a chain of two loads
    clearProg();
    prog[0] = '{C_LD,  5'd1, 5'd0, 5'd3};
    prog[1] = '{C_LD,  5'd7, 5'd3, 5'd5};
    prog[2] = '{C_SUB, 5'd5, 5'd9, 5'd4};
    startRun();
    push(8,  1'b0, C_LD,  "R2 stall on srcB");
    push(8,  1'b1, 8'h00, "R6 R7 bubble then release");
    push(12, 1'b0, C_LD,  "R9 second load stalls its user");
    push(12, 1'b1, 8'h00, "R9 R6 second bubble");
    push(16, 1'b1, C_SUB, "R9 R5 user enters execute");
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      nFails++;
      $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule